// File: doc/BRIEF.md
# Buffer Descriptor List Walker

This block walks a list of buffer descriptors that software has placed in system memory for one direction of a packet engine, either transmit or receive. Software writes a list base address, selects the layout, and pulses start. The walker then reads one 16-byte descriptor at a time through a memory-read request/response port. It extracts the buffer addresses and sizes and offers each buffer to a data mover through a valid/ready handoff. When the data mover has taken every buffer of a descriptor, the walker writes the first descriptor word back with the ownership bit cleared, and then moves on.

Two layouts are supported. In the ring layout, descriptors lie back to back, each one can name two buffers, and an end flag sends the walker back to the list base. In the chain layout, each descriptor names one buffer and its last word points to the next descriptor. A descriptor still owned by software suspends the walker until a poll pulse arrives. A stop request is honoured only between descriptors. One instance serves one direction, so transmit and receive are two instances that start and stop independently.

Descriptor layout, in 32-bit words at ascending addresses: word 0 holds the ownership bit at bit 31 (1 = owned by the walker) and the ring end flag at bit 21. Word 1 holds the first buffer size in bits 12:0 and the second buffer size in bits 28:16. Word 2 holds the first buffer address. Word 3 holds the second buffer address in the ring layout and the next descriptor address in the chain layout.

Top module: `desc_walker`

## Requirements
- R1: After reset the walker is stopped: running_o, suspended_o, rd_req_o, buf_valid_o and wr_req_o are all low.
- R2: A start pulse while stopped captures base_addr_i, chain_mode_i and burst_lim_i, raises running_o, and issues the first descriptor read at the base address.
- R3: Each descriptor is read as 4 consecutive words in requests of min(limit, 4) words each, where a limit of 0 counts as 1. No request is longer than that.
- R4: In the ring layout, buffer 1 (word 2, size from word 1 bits 12:0) is offered first. Buffer 2 (word 3, size from word 1 bits 28:16) is offered next only if its size is nonzero. The next descriptor sits at the current address plus 16.
- R5: In the ring layout, a descriptor with word 0 bit 21 set makes the next descriptor address equal to the list base.
- R6: In the chain layout, only buffer 1 is offered. The second size and the end flag are ignored, and the next descriptor address is taken from word 3.
- R7: A descriptor with word 0 bit 31 clear offers no buffer and sets suspended_o. A poll_i pulse then re-reads the same descriptor address.
- R8: After the last buffer of a descriptor is accepted, word 0 is written back to the descriptor address with bit 31 cleared. This happens before the next descriptor is read.
- R9: A stop_i pulse during a descriptor lets its buffers and write-back complete, then drops running_o without reading another descriptor.
- R10: A stop_i pulse while suspended returns the walker to the stopped state on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| base_addr_i | input | 32 | Descriptor list base address |
| chain_mode_i | input | 1 | 1 = chain layout, 0 = ring layout |
| burst_lim_i | input | LW (6) | Read burst length limit in words |
| start_i | input | 1 | Start pulse |
| stop_i | input | 1 | Stop request pulse |
| poll_i | input | 1 | Poll pulse that resumes from suspension |
| rd_req_o | output | 1 | Descriptor read request |
| rd_addr_o | output | 32 | Read start address |
| rd_len_o | output | 3 | Read length in words |
| rd_gnt_i | input | 1 | Read request accepted |
| rd_valid_i | input | 1 | Read data word valid |
| rd_data_i | input | 32 | Read data word |
| buf_valid_o | output | 1 | Buffer offered to data mover |
| buf_addr_o | output | 32 | Buffer address |
| buf_size_o | output | 13 | Buffer size in bytes |
| buf_ready_i | input | 1 | Data mover accepts buffer |
| wr_req_o | output | 1 | Descriptor write-back request |
| wr_addr_o | output | 32 | Write-back address |
| wr_data_o | output | 32 | Write-back word 0 |
| wr_gnt_i | input | 1 | Write-back accepted |
| running_o | output | 1 | Walker not stopped |
| suspended_o | output | 1 | Walker waiting on a software-owned descriptor |

## Verification
A wrong next-descriptor address shows at the buffer port within one descriptor time. The walker then offers a buffer that the layout should never reach, or it suspends after the wrong number of handoffs. A lost ownership clear lets the ring spin past its wrap point, and the bench sees this as extra handoffs before suspension. A bad fetch counter shows up in the request length on the very next read request. A stop that is honoured too early or too late changes how many buffers and write-backs appear before running_o falls.

// File: rtl/dw_pkg.sv
package dw_pkg;
  localparam int DW      = 32;
  localparam int SW      = 13;
  localparam int WORDS   = 4;
  localparam int LENW    = $clog2(WORDS + 1);
  localparam int OWN_BIT = 31;
  localparam int EOR_BIT = 21;
  localparam int SZ1_LSB = 0;
  localparam int SZ2_LSB = 16;
  localparam int DESC_BYTES = WORDS * (DW / 8);

  typedef logic [WORDS-1:0][DW-1:0] desc_words_t;

  typedef struct packed {
    logic [SW-1:0] size1;
    logic [SW-1:0] size2;
    logic [DW-1:0] buf1;
    logic [DW-1:0] buf2;
    logic [DW-1:0] next_addr;
    logic [DW-1:0] word0;
  } desc_info_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_BUF1, ST_BUF2, ST_WB, ST_SUSP
  } walk_state_t;
endpackage

// File: rtl/dw_fetch.sv
module dw_fetch
  import dw_pkg::*;
#(
  parameter int LW = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            go_i,
  input  logic [DW-1:0]   addr_i,
  input  logic [LW-1:0]   lim_i,
  output logic            rd_req_o,
  output logic [DW-1:0]   rd_addr_o,
  output logic [LENW-1:0] rd_len_o,
  input  logic            rd_gnt_i,
  input  logic            rd_valid_i,
  input  logic [DW-1:0]   rd_data_i,
  output desc_words_t     words_o,
  output logic            done_o
);
  localparam int IW = $clog2(WORDS);

  logic [LENW-1:0] cnt_q, outst_q, eff_lim, left;
  desc_words_t     words_q;

  always_comb begin
    if (lim_i == '0)                 eff_lim = LENW'(1);
    else if (lim_i >= LW'(WORDS))    eff_lim = LENW'(WORDS);
    else                             eff_lim = lim_i[LENW-1:0];
  end

  assign left      = LENW'(WORDS) - cnt_q;
  assign rd_len_o  = (eff_lim < left) ? eff_lim : left;
  assign rd_req_o  = go_i && (cnt_q < LENW'(WORDS)) && (outst_q == '0);
  assign rd_addr_o = addr_i + DW'({cnt_q, 2'b00});
  assign done_o    = go_i && (cnt_q == LENW'(WORDS));
  assign words_o   = words_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      outst_q <= '0;
      words_q <= '0;
    end else if (!go_i) begin
      cnt_q   <= '0;
      outst_q <= '0;
    end else if (rd_req_o && rd_gnt_i) begin
      outst_q <= rd_len_o;
    end else if (rd_valid_i && outst_q != '0) begin
      words_q[cnt_q[IW-1:0]] <= rd_data_i;
      cnt_q   <= cnt_q + LENW'(1);
      outst_q <= outst_q - LENW'(1);
    end
  end
endmodule

// File: rtl/dw_decode.sv
module dw_decode
  import dw_pkg::*;
(
  input  desc_words_t   words_i,
  input  logic          chain_i,
  input  logic [DW-1:0] cur_i,
  input  logic [DW-1:0] base_i,
  output desc_info_t    info_o
);
  logic eor;
  logic unused_w1;

  assign eor       = words_i[0][EOR_BIT];
  assign unused_w1 = ^words_i[1];

  always_comb begin
    info_o.word0 = words_i[0];
    info_o.size1 = words_i[1][SZ1_LSB +: SW];
    info_o.size2 = chain_i ? '0 : words_i[1][SZ2_LSB +: SW];
    info_o.buf1  = words_i[2];
    info_o.buf2  = words_i[3];
    if (chain_i)  info_o.next_addr = words_i[3];
    else if (eor) info_o.next_addr = base_i;
    else          info_o.next_addr = cur_i + DW'(DESC_BYTES);
  end
endmodule

// File: rtl/desc_walker.sv
module desc_walker
  import dw_pkg::*;
#(
  parameter int LW = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [31:0]     base_addr_i,
  input  logic            chain_mode_i,
  input  logic [LW-1:0]   burst_lim_i,
  input  logic            start_i,
  input  logic            stop_i,
  input  logic            poll_i,
  output logic            rd_req_o,
  output logic [31:0]     rd_addr_o,
  output logic [2:0]      rd_len_o,
  input  logic            rd_gnt_i,
  input  logic            rd_valid_i,
  input  logic [31:0]     rd_data_i,
  output logic            buf_valid_o,
  output logic [31:0]     buf_addr_o,
  output logic [12:0]     buf_size_o,
  input  logic            buf_ready_i,
  output logic            wr_req_o,
  output logic [31:0]     wr_addr_o,
  output logic [31:0]     wr_data_o,
  input  logic            wr_gnt_i,
  output logic            running_o,
  output logic            suspended_o
);
  walk_state_t   state_q;
  logic [DW-1:0] base_q, cur_q;
  logic          chain_q, stop_q;
  logic [LW-1:0] lim_q;
  desc_info_t    info_q, dec;
  desc_words_t   words;
  logic          fetch_done;

  dw_fetch #(.LW(LW)) u_fetch (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .go_i       (state_q == ST_FETCH),
    .addr_i     (cur_q),
    .lim_i      (lim_q),
    .rd_req_o   (rd_req_o),
    .rd_addr_o  (rd_addr_o),
    .rd_len_o   (rd_len_o),
    .rd_gnt_i   (rd_gnt_i),
    .rd_valid_i (rd_valid_i),
    .rd_data_i  (rd_data_i),
    .words_o    (words),
    .done_o     (fetch_done)
  );

  dw_decode u_decode (
    .words_i (words),
    .chain_i (chain_q),
    .cur_i   (cur_q),
    .base_i  (base_q),
    .info_o  (dec)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      base_q  <= '0;
      cur_q   <= '0;
      chain_q <= 1'b0;
      lim_q   <= '0;
      stop_q  <= 1'b0;
      info_q  <= '0;
    end else begin
      if (stop_i && state_q != ST_IDLE) stop_q <= 1'b1;
      unique case (state_q)
        ST_IDLE: begin
          stop_q <= 1'b0;
          if (start_i) begin
            base_q  <= base_addr_i;
            cur_q   <= base_addr_i;
            chain_q <= chain_mode_i;
            lim_q   <= burst_lim_i;
            state_q <= ST_FETCH;
          end
        end
        ST_FETCH: if (fetch_done) begin
          info_q  <= dec;
          state_q <= dec.word0[OWN_BIT] ? ST_BUF1 : ST_SUSP;
        end
        ST_BUF1: if (buf_ready_i)
          state_q <= (info_q.size2 != '0) ? ST_BUF2 : ST_WB;
        ST_BUF2: if (buf_ready_i) state_q <= ST_WB;
        ST_WB: if (wr_gnt_i) begin
          cur_q   <= info_q.next_addr;
          state_q <= (stop_q || stop_i) ? ST_IDLE : ST_FETCH;
        end
        ST_SUSP: begin
          if (stop_q || stop_i) state_q <= ST_IDLE;
          else if (poll_i)      state_q <= ST_FETCH;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign buf_valid_o = (state_q == ST_BUF1) || (state_q == ST_BUF2);
  assign buf_addr_o  = (state_q == ST_BUF2) ? info_q.buf2  : info_q.buf1;
  assign buf_size_o  = (state_q == ST_BUF2) ? info_q.size2 : info_q.size1;
  assign wr_req_o    = (state_q == ST_WB);
  assign wr_addr_o   = cur_q;
  assign wr_data_o   = info_q.word0 & ~(DW'(1) << OWN_BIT);
  assign running_o   = (state_q != ST_IDLE);
  assign suspended_o = (state_q == ST_SUSP);
endmodule

// File: rtl/dw_chk.sv
module dw_chk #(
  parameter int LW = 6
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [LW-1:0] burst_lim_i,
  input logic          stop_i,
  input logic          rd_req_o,
  input logic [2:0]    rd_len_o,
  input logic          buf_valid_o,
  input logic [31:0]   buf_addr_o,
  input logic [12:0]   buf_size_o,
  input logic          buf_ready_i,
  input logic          wr_req_o,
  input logic [31:0]   wr_data_o,
  input logic          running_o,
  input logic          suspended_o
);
  assert_stopped_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !running_o |-> !rd_req_o && !buf_valid_o && !wr_req_o && !suspended_o);

  assert_burst_len_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> rd_len_o != 3'd0 && rd_len_o <= 3'd4 &&
      ((burst_lim_i == '0) ? (rd_len_o == 3'd1) : (LW'(rd_len_o) <= burst_lim_i)));

  assert_buf_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_valid_o && !buf_ready_i |=> buf_valid_o && $stable(buf_addr_o) && $stable(buf_size_o));

  assert_suspend_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    suspended_o |-> !rd_req_o && !buf_valid_o && !wr_req_o);

  assert_wb_clears_own_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o |-> !wr_data_o[31] && !rd_req_o && !buf_valid_o);

  assert_stop_in_suspend_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    suspended_o && stop_i |=> !running_o);
endmodule

bind desc_walker dw_chk #(.LW(LW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .burst_lim_i (burst_lim_i),
  .stop_i      (stop_i),
  .rd_req_o    (rd_req_o),
  .rd_len_o    (rd_len_o),
  .buf_valid_o (buf_valid_o),
  .buf_addr_o  (buf_addr_o),
  .buf_size_o  (buf_size_o),
  .buf_ready_i (buf_ready_i),
  .wr_req_o    (wr_req_o),
  .wr_data_o   (wr_data_o),
  .running_o   (running_o),
  .suspended_o (suspended_o)
);

// File: tb/sim_desc_walker.sv
`timescale 1ns/1ps
module sim_desc_walker;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [31:0] base_addr = '0;
  logic        chain_mode = 1'b0;
  logic [5:0]  burst_lim = 6'd4;
  logic        start = 1'b0, stop = 1'b0, poll = 1'b0;
  logic        rd_req, rd_gnt, rd_valid;
  logic [31:0] rd_addr, rd_data;
  logic [2:0]  rd_len;
  logic        buf_valid, buf_ready = 1'b1;
  logic [31:0] buf_addr;
  logic [12:0] buf_size;
  logic        wr_req, wr_gnt;
  logic [31:0] wr_addr, wr_data;
  logic        running, suspended;

  always #2.5 clk = ~clk;

  desc_walker u0 (
    .clk_i(clk), .rst_ni(rst_n), .base_addr_i(base_addr), .chain_mode_i(chain_mode),
    .burst_lim_i(burst_lim), .start_i(start), .stop_i(stop), .poll_i(poll),
    .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_len_o(rd_len), .rd_gnt_i(rd_gnt),
    .rd_valid_i(rd_valid), .rd_data_i(rd_data), .buf_valid_o(buf_valid),
    .buf_addr_o(buf_addr), .buf_size_o(buf_size), .buf_ready_i(buf_ready),
    .wr_req_o(wr_req), .wr_addr_o(wr_addr), .wr_data_o(wr_data), .wr_gnt_i(wr_gnt),
    .running_o(running), .suspended_o(suspended)
  );

  // memory model: 64 words, command-driven setup, write-back port
  logic [31:0] mem [64];
  logic [1:0]  mem_cmd = 2'd0;
  localparam logic [31:0] OWN = 32'h8000_0000, EOR = 32'h0020_0000;

  always @(posedge clk) begin
    case (mem_cmd)
      2'd1, 2'd2: begin
        for (int i = 0; i < 64; i++) mem[i] <= 32'h0;
        // ring list at 0x00
        mem[0] <= OWN;        mem[1] <= {3'd0, 13'h020, 3'd0, 13'h010};
        mem[2] <= 32'h100;    mem[3] <= 32'h200;
        mem[4] <= OWN | EOR;  mem[5] <= 32'h30;
        mem[6] <= 32'h300;    mem[7] <= 32'h0;
        mem[8] <= OWN;        mem[9] <= 32'h11;  mem[10] <= 32'h999;
        // chain list at 0x80
        mem[32] <= OWN | EOR; mem[33] <= {3'd0, 13'h007, 3'd0, 13'h040};
        mem[34] <= 32'h400;   mem[35] <= 32'hC0;
        mem[36] <= OWN;       mem[37] <= 32'h22; mem[38] <= 32'h888;
        mem[48] <= OWN;       mem[49] <= 32'h50;
        mem[50] <= 32'h500;   mem[51] <= 32'h80;
      end
      2'd3: mem[0] <= mem[0] | OWN;
      default: if (wr_req && wr_gnt) mem[wr_addr[7:2]] <= wr_data;
    endcase
  end

  assign rd_gnt = rd_req;
  assign wr_gnt = wr_req;

  logic [31:0] rsp_addr;
  logic [2:0]  rsp_n;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_n <= 3'd0; rsp_addr <= 32'h0;
    end else if (rd_req && rd_gnt) begin
      rsp_addr <= rd_addr; rsp_n <= rd_len;
    end else if (rsp_n != 3'd0) begin
      rsp_addr <= rsp_addr + 32'd4; rsp_n <= rsp_n - 3'd1;
    end
  end
  assign rd_valid = (rsp_n != 3'd0);
  assign rd_data  = mem[rsp_addr[7:2]];

  // observation log
  logic        clr = 1'b0;
  int          n_hand, n_wr;
  logic [31:0] last_a, first_addr;
  logic [12:0] last_s;
  logic [2:0]  max_len;
  logic        first_seen, saw10;
  always @(posedge clk) begin
    if (clr) begin
      n_hand <= 0; n_wr <= 0; max_len <= 3'd0; first_seen <= 1'b0; saw10 <= 1'b0;
      last_a <= 32'h0; last_s <= 13'h0; first_addr <= 32'hFFFF_FFFF;
    end else begin
      if (buf_valid && buf_ready) begin
        n_hand <= n_hand + 1; last_a <= buf_addr; last_s <= buf_size;
      end
      if (rd_req) begin
        if (rd_len > max_len) max_len <= rd_len;
        if (!first_seen) begin first_seen <= 1'b1; first_addr <= rd_addr; end
        if (rd_addr == 32'h10) saw10 <= 1'b1;
      end
      if (wr_req && wr_gnt) n_wr <= n_wr + 1;
    end
  end

  int  n_chk = 0, n_bad = 0;
  bit  fin = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulse_clr();
    @(negedge clk); clr = 1'b1; @(negedge clk); clr = 1'b0;
  endtask
  task automatic load_mem(input logic [1:0] cmd);
    @(negedge clk); mem_cmd = cmd; @(negedge clk); mem_cmd = 2'd0;
  endtask
  task automatic pulse_start();
    @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
  endtask
  task automatic pulse_stop();
    @(negedge clk); stop = 1'b1; @(negedge clk); stop = 1'b0;
  endtask
  task automatic pulse_poll();
    @(negedge clk); poll = 1'b1; @(negedge clk); poll = 1'b0;
  endtask
  task automatic wait_susp();
    for (int i = 0; i < 2000 && !suspended; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  typedef struct packed {
    logic        chain;
    logic [5:0]  lim;
    logic [7:0]  base;
    logic [3:0]  exp_n;
    logic [15:0] exp_a;
    logic [12:0] exp_s;
    logic [2:0]  exp_max;
    logic [7:0]  second;
  } vec_t;

  localparam vec_t VEC [5] = '{
    '{1'b0, 6'd4, 8'h00, 4'd3, 16'h300, 13'h30, 3'd4, 8'h10},
    '{1'b0, 6'd1, 8'h00, 4'd3, 16'h300, 13'h30, 3'd1, 8'h10},
    '{1'b0, 6'd0, 8'h00, 4'd3, 16'h300, 13'h30, 3'd1, 8'h10},
    '{1'b1, 6'd3, 8'h80, 4'd2, 16'h500, 13'h50, 3'd3, 8'hC0},
    '{1'b1, 6'd9, 8'h80, 4'd2, 16'h500, 13'h50, 3'd4, 8'hC0}
  };

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 running", 32'(running), 32'd0);
    chk("R1 rd_req", 32'(rd_req), 32'd0);
    chk("R1 buf_valid", 32'(buf_valid), 32'd0);
    chk("R1 wr_req", 32'(wr_req), 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 suspended after reset", 32'(suspended), 32'd0);

    foreach (VEC[k]) begin
      load_mem(2'd1);
      chain_mode = VEC[k].chain;
      burst_lim  = VEC[k].lim;
      base_addr  = 32'(VEC[k].base);
      pulse_clr();
      pulse_start();
      wait_susp();
      chk("R2 first read address", first_addr, 32'(VEC[k].base));
      chk("R3 max burst", 32'(max_len), 32'(VEC[k].exp_max));
      chk(VEC[k].chain ? "R6 handoff count" : "R5 handoff count", 32'(n_hand), 32'(VEC[k].exp_n));
      chk(VEC[k].chain ? "R6 last buffer addr" : "R4 last buffer addr", last_a, 32'(VEC[k].exp_a));
      chk(VEC[k].chain ? "R6 last buffer size" : "R4 last buffer size", 32'(last_s), 32'(VEC[k].exp_s));
      chk("R7 suspended on cleared own", 32'(suspended), 32'd1);
      chk("R8 write-back count", 32'(n_wr), 32'd2);
      chk("R8 own cleared first", 32'(mem[VEC[k].base[7:2]][31]), 32'd0);
      chk("R8 own cleared second", 32'(mem[VEC[k].second[7:2]][31]), 32'd0);
      pulse_stop();
      @(negedge clk);
      chk("R10 stop while suspended", 32'(running), 32'd0);
    end

    // R7: poll resumes at the same descriptor
    load_mem(2'd1);
    chain_mode = 1'b0; burst_lim = 6'd4; base_addr = 32'h0;
    pulse_start();
    wait_susp();
    pulse_clr();
    load_mem(2'd3);
    pulse_poll();
    @(negedge clk);
    wait_susp();
    chk("R7 refetch addr after poll", first_addr, 32'h0);
    chk("R7 handoffs after poll", 32'(n_hand), 32'd2);
    chk("R7 last buffer after poll", last_a, 32'h200);
    pulse_stop();
    @(negedge clk);

    // R9: stop mid-descriptor completes it, then halts
    load_mem(2'd1);
    buf_ready = 1'b0;
    pulse_clr();
    pulse_start();
    for (int i = 0; i < 200 && !buf_valid; i++) @(negedge clk);
    chk("R2 running after start", 32'(running), 32'd1);
    pulse_stop();
    buf_ready = 1'b1;
    for (int i = 0; i < 200 && running; i++) @(negedge clk);
    repeat (2) @(negedge clk);
    chk("R9 stopped", 32'(running), 32'd0);
    chk("R9 buffers of current descriptor", 32'(n_hand), 32'd2);
    chk("R9 write-back done", 32'(mem[0][31]), 32'd0);
    chk("R9 next descriptor untouched", 32'(mem[4][31]), 32'd1);
    chk("R9 no further read", 32'(saw10), 32'd0);

    fin = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!fin) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
    end
  end
endmodule